// File: doc/BRIEF.md
# Two-Stage In-Order Processor Core

This block is a small in-order processor split into two pipeline stages. The front stage reads an instruction, decodes it and reads its source registers. It then writes an executable entry into a one-slot buffer between the stages. That entry holds operand values and a destination register name, never source register names, so the back stage never touches the register file for reading. Each cycle the back stage performs the buffered operation: an add, a load, a store or a branch-if-zero. It then writes its result back to the register file or to data memory.

Read-after-write hazards between the two stages are handled in one of two ways, picked by a mode pin. In interlock mode, decode compares its source registers against the destination of the buffered entry. On a match it holds the program counter and inserts a bubble. In forwarding mode, a result that is being written back in the same cycle is passed directly into decode, so the pipeline never stalls. A taken branch redirects fetch and discards the entry that was fetched behind it. The instruction port and the data port both return read data in the same cycle as the address.

Top module: `tp2_core`

## Requirements
- R1: An instruction is 11 bits. Bits [10:9] hold the opcode (0 add, 1 branch-if-zero, 2 load, 3 store), with register fields A=[8:6], B=[5:3] and C=[2:0]. Add uses A as destination and B, C as sources. Branch uses A as condition and B as target. Load uses A as destination and B as address. Store uses A as the stored value and B as address.
- R2: While reset is held, the fetch address is 0, no store is issued and the buffer is empty. All eight registers read as zero after reset.
- R3: Add writes the 16-bit wrapping sum of its two operand values to its destination register.
- R4: Load writes the data word at the address value into its destination. Store writes the value operand to the address value.
- R5: A branch whose condition value is zero loads the fetch address with the low 8 bits of its target value on the next edge. The instruction fetched in that cycle is discarded and never executes.
- R6: A branch whose condition value is nonzero has no effect, and fetch continues in sequence.
- R7: In interlock mode, when a source field of the fetched instruction names the destination of a buffered add or load, the fetch address is held for one cycle and a bubble is inserted.
- R8: A buffered store or branch never causes a stall, even when its A field matches a source of the fetched instruction.
- R9: In forwarding mode the fetch address never stalls. A source that names the register being written back in the same cycle receives the value being written.
- R10: With no hazard and no taken branch, the fetch address increments by one every cycle. A full buffer is emptied and refilled on the same edge.
- R11: In both modes, the final data memory contents of any program equal those produced by sequential execution of the same instruction stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| byp_en | input | 1 | 1 selects forwarding mode, 0 selects interlock mode; held constant while running |
| imem_addr | output | 8 | Instruction word address (the program counter) |
| imem_rdata | input | 11 | Instruction at imem_addr, valid in the same cycle |
| dmem_addr | output | 16 | Data memory word address |
| dmem_wdata | output | 16 | Store data |
| dmem_we | output | 1 | Store strobe, write on the rising edge |
| dmem_rdata | input | 16 | Data word at dmem_addr, valid in the same cycle |

## Verification
Six short programs run in both modes, and each program's final memory image is compared with an in-bench sequential interpreter. The dependent-add chains and the load-use chains separate a correct interlock or forwarding path from a stale register read. The taken-branch program has a poisoned instruction in the shadow of the branch, so a missing squash shows up in memory. The not-taken program and the store-then-load program catch a wrongly redirected fetch and wrong ordering of memory writes. Cycle-exact probes of the fetch address tell the modes apart: a one-cycle hold in interlock mode versus none in forwarding mode, no hold behind a store, an immediate redirect on a taken branch, and full rate on independent adds.

// File: rtl/tp2_pkg.sv
package tp2_pkg;
    localparam int XLEN = 16;
    localparam int RW   = 3;
    localparam int NREG = 1 << RW;
    localparam int IAW  = 8;
    localparam int OPW  = 2;
    localparam int IW   = OPW + 3 * RW;
    localparam int NRD  = 3;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RW-1:0]   rname_t;
    typedef logic [IAW-1:0]  iaddr_t;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 2'd0,
        OP_BZ  = 2'd1,
        OP_LD  = 2'd2,
        OP_ST  = 2'd3
    } op_e;

    // executable entry held between the stages
    typedef struct packed {
        logic   valid;
        op_e    op;
        rname_t dst;
        word_t  v1;
        word_t  v2;
    } tmpl_t;
endpackage

// File: rtl/tp2_regfile.sv
module tp2_regfile
    import tp2_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  rname_t raddr [NRD],
    output word_t  rdata [NRD],
    input  logic   we,
    input  rname_t waddr,
    input  word_t  wdata
);
    word_t regs_q [NREG];
    word_t regs_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n) regs_q[i] <= '0;
            else        regs_q[i] <= regs_d[i];
        end
    end

    // reads see the value from before this cycle's write
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = regs_q[raddr[g]];
    end
endmodule

// File: rtl/tp2_decode.sv
module tp2_decode
    import tp2_pkg::*;
(
    input  logic [IW-1:0] instr,
    input  word_t         rv_a,
    input  word_t         rv_b,
    input  word_t         rv_c,
    input  tmpl_t         held,
    input  logic          byp_en,
    input  logic          fwd_vld,
    input  rname_t        fwd_rd,
    input  word_t         fwd_val,
    output rname_t        fa,
    output rname_t        fb,
    output rname_t        fc,
    output tmpl_t         tmpl,
    output logic          stall
);
    op_e  op;
    logic use_a, use_c;
    logic held_writes;
    word_t va, vb, vc;

    function automatic word_t pick(input rname_t r, input word_t rv, input logic byp,
                                   input logic fv, input rname_t frd, input word_t fval);
        return (byp && fv && (r == frd)) ? fval : rv;
    endfunction

    assign op = op_e'(instr[IW-1 -: OPW]);
    assign fa = instr[3*RW-1 -: RW];
    assign fb = instr[2*RW-1 -: RW];
    assign fc = instr[RW-1:0];

    always_comb begin
        use_a       = (op == OP_BZ) || (op == OP_ST);
        use_c       = (op == OP_ADD);
        held_writes = held.valid && ((held.op == OP_ADD) || (held.op == OP_LD));

        stall = 1'b0;
        if (!byp_en && held_writes) begin
            stall = (use_a && (fa == held.dst)) ||
                    (fb == held.dst) ||
                    (use_c && (fc == held.dst));
        end

        va = pick(fa, rv_a, byp_en, fwd_vld, fwd_rd, fwd_val);
        vb = pick(fb, rv_b, byp_en, fwd_vld, fwd_rd, fwd_val);
        vc = pick(fc, rv_c, byp_en, fwd_vld, fwd_rd, fwd_val);

        tmpl.valid = 1'b1;
        tmpl.op    = op;
        tmpl.dst   = fa;
        tmpl.v1    = (op == OP_ADD) ? vb : va;
        tmpl.v2    = (op == OP_ADD) ? vc : vb;
    end
endmodule

// File: rtl/tp2_exec.sv
module tp2_exec
    import tp2_pkg::*;
(
    input  tmpl_t  ent,
    input  word_t  dmem_rdata,
    output word_t  dmem_addr,
    output word_t  dmem_wdata,
    output logic   dmem_we,
    output logic   rf_we,
    output rname_t rf_wa,
    output word_t  rf_wd,
    output logic   br_taken,
    output iaddr_t br_target
);
    always_comb begin
        dmem_addr  = ent.v2;
        dmem_wdata = ent.v1;
        dmem_we    = ent.valid && (ent.op == OP_ST);
        rf_we      = ent.valid && ((ent.op == OP_ADD) || (ent.op == OP_LD));
        rf_wa      = ent.dst;
        rf_wd      = (ent.op == OP_ADD) ? (ent.v1 + ent.v2) : dmem_rdata;
        br_taken   = ent.valid && (ent.op == OP_BZ) && (ent.v1 == '0);
        br_target  = ent.v2[IAW-1:0];
    end
endmodule

// File: rtl/tp2_core.sv
module tp2_core
    import tp2_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                byp_en,
    output logic [IAW-1:0]      imem_addr,
    input  logic [IW-1:0]       imem_rdata,
    output logic [XLEN-1:0]     dmem_addr,
    output logic [XLEN-1:0]     dmem_wdata,
    output logic                dmem_we,
    input  logic [XLEN-1:0]     dmem_rdata
);
    typedef struct packed {
        iaddr_t pc;
        tmpl_t  ent;
    } core_st_t;

    core_st_t st_q, st_d;

    rname_t fa, fb, fc;
    rname_t rd_addr [NRD];
    word_t  rd_data [NRD];
    tmpl_t  dec_tmpl;
    logic   hz_stall;
    logic   rf_we;
    rname_t rf_wa;
    word_t  rf_wd;
    logic   br_taken;
    iaddr_t br_target;
    logic   ent_vld;

    assign rd_addr[0] = fa;
    assign rd_addr[1] = fb;
    assign rd_addr[2] = fc;
    assign imem_addr  = st_q.pc;
    assign ent_vld    = st_q.ent.valid;

    tp2_regfile u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (rd_addr),
        .rdata (rd_data),
        .we    (rf_we),
        .waddr (rf_wa),
        .wdata (rf_wd)
    );

    tp2_decode u_dec (
        .instr   (imem_rdata),
        .rv_a    (rd_data[0]),
        .rv_b    (rd_data[1]),
        .rv_c    (rd_data[2]),
        .held    (st_q.ent),
        .byp_en  (byp_en),
        .fwd_vld (rf_we),
        .fwd_rd  (rf_wa),
        .fwd_val (rf_wd),
        .fa      (fa),
        .fb      (fb),
        .fc      (fc),
        .tmpl    (dec_tmpl),
        .stall   (hz_stall)
    );

    tp2_exec u_ex (
        .ent        (st_q.ent),
        .dmem_rdata (dmem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .rf_we      (rf_we),
        .rf_wa      (rf_wa),
        .rf_wd      (rf_wd),
        .br_taken   (br_taken),
        .br_target  (br_target)
    );

    // execute drains the buffer every cycle; fetch refills it on the same edge
    always_comb begin
        st_d = st_q;
        if (br_taken) begin
            st_d.pc        = br_target;
            st_d.ent       = '0;
        end else if (hz_stall) begin
            st_d.ent       = '0;
        end else begin
            st_d.pc        = st_q.pc + iaddr_t'(1);
            st_d.ent       = dec_tmpl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tp2_chk.sv
module tp2_chk
    import tp2_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   byp_en,
    input iaddr_t pc,
    input logic   buf_valid,
    input logic   stall,
    input logic   br_taken,
    input iaddr_t br_target,
    input logic   dmem_we,
    input logic   rf_we
);
    // R5
    squash_after_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> !buf_valid);

    // R5
    redirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> (pc == $past(br_target)));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !br_taken) |=> (!buf_valid && pc == $past(pc)));

    // R9
    fwd_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_en && !br_taken) |=> (pc == $past(pc) + iaddr_t'(1)));

    // R10
    empty_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_valid |-> !stall);

    // R4
    store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> !rf_we);
endmodule

bind tp2_core tp2_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byp_en    (byp_en),
    .pc        (imem_addr),
    .buf_valid (ent_vld),
    .stall     (hz_stall),
    .br_taken  (br_taken),
    .br_target (br_target),
    .dmem_we   (dmem_we),
    .rf_we     (rf_we)
);

// File: tb/test_tp2_core.sv
module test_tp2_core;
    localparam int PLEN = 32;
    localparam int MLEN = 16;
    localparam logic [10:0] NOP = {2'd0, 3'd7, 3'd7, 3'd7};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byp_en = 1'b0;
    logic        ld_mem = 1'b0;
    logic [7:0]  imem_addr;
    logic [10:0] imem_rdata;
    logic [15:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [10:0] prog [PLEN];
    logic [15:0] dmem [MLEN];
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    tp2_core i_tp2_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .byp_en     (byp_en),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    function automatic logic [15:0] init_word(input int i);
        return (i == 0) ? 16'd8 : 16'(i * 3 + 2);
    endfunction

    assign imem_rdata = (imem_addr < 8'(PLEN)) ? prog[imem_addr[4:0]] : NOP;
    assign dmem_rdata = dmem[dmem_addr[3:0]];

    always @(posedge clk) begin
        if (ld_mem) begin
            for (int i = 0; i < MLEN; i++) dmem[i] <= init_word(i);
        end else if (dmem_we) begin
            dmem[dmem_addr[3:0]] <= dmem_wdata;
        end
    end

    // R1 field layout: op[10:9] A[8:6] B[5:3] C[2:0]
    function automatic logic [10:0] enc(input int op, input int a, input int b, input int c);
        return {2'(op), 3'(a), 3'(b), 3'(c)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < PLEN; i++) prog[i] = NOP;
    endtask

    // after return: negedge right after reset release; next posedge is edge 1
    task automatic do_reset(input logic mode);
        rst_n  = 1'b0;
        ld_mem = 1'b1;
        byp_en = mode;
        repeat (3) @(posedge clk);
        @(negedge clk);
        ld_mem = 1'b0;
        rst_n  = 1'b1;
    endtask

    // sequential interpreter, R11 reference
    task automatic ref_run(output logic [15:0] m [MLEN]);
        logic [15:0] r [8];
        logic [7:0]  pc;
        logic [10:0] ins;
        int op, a, b, c;
        for (int i = 0; i < 8; i++) r[i] = '0;
        for (int i = 0; i < MLEN; i++) m[i] = init_word(i);
        pc = '0;
        for (int s = 0; s < 48; s++) begin
            ins = (pc < 8'(PLEN)) ? prog[pc[4:0]] : NOP;
            op = int'(ins[10:9]); a = int'(ins[8:6]); b = int'(ins[5:3]); c = int'(ins[2:0]);
            pc = pc + 8'd1;
            case (op)
                0: r[a] = r[b] + r[c];
                1: if (r[a] == 16'd0) pc = r[b][7:0];
                2: r[a] = m[r[b][3:0]];
                default: m[r[b][3:0]] = r[a];
            endcase
        end
    endtask

    task automatic run_and_compare(input string name);
        logic [15:0] exp_m [MLEN];
        for (int md = 0; md < 2; md++) begin
            do_reset(md[0]);
            repeat (150) @(negedge clk);
            ref_run(exp_m);
            for (int i = 0; i < MLEN; i++) begin
                if (dmem[i] !== exp_m[i])
                    $display("  %s mode=%0d word %0d differs", name, md, i);
                chk(dmem[i] === exp_m[i], "R11", int'(dmem[i]), int'(exp_m[i]));
            end
        end
    endtask

    task automatic t_reset();
        clear_prog();
        rst_n = 1'b0; ld_mem = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(imem_addr == 8'd0, "R2 pc", int'(imem_addr), 0);
        chk(dmem_we == 1'b0, "R2 we", int'(dmem_we), 0);
    endtask

    task automatic t_stall_vs_fwd();
        clear_prog();
        prog[0] = enc(0, 1, 2, 3);
        prog[1] = enc(0, 4, 1, 1);
        do_reset(1'b0);
        repeat (2) @(negedge clk);
        chk(imem_addr == 8'd1, "R7 hold", int'(imem_addr), 1);
        @(negedge clk);
        chk(imem_addr == 8'd2, "R7 resume", int'(imem_addr), 2);
        do_reset(1'b1);
        repeat (2) @(negedge clk);
        chk(imem_addr == 8'd2, "R9 no hold", int'(imem_addr), 2);
    endtask

    task automatic t_store_no_stall();
        clear_prog();
        prog[0] = enc(3, 1, 2, 0);
        prog[1] = enc(0, 3, 1, 1);
        do_reset(1'b0);
        repeat (2) @(negedge clk);
        chk(imem_addr == 8'd2, "R8", int'(imem_addr), 2);
    endtask

    task automatic t_taken_timing();
        clear_prog();
        prog[0] = enc(1, 7, 7, 0);
        prog[1] = enc(3, 7, 7, 0);
        do_reset(1'b0);
        @(negedge clk);
        chk(imem_addr == 8'd1, "R5 seq", int'(imem_addr), 1);
        @(negedge clk);
        chk(imem_addr == 8'd0, "R5 redirect", int'(imem_addr), 0);
        chk(dmem_we == 1'b0, "R5 squash", int'(dmem_we), 0);
    endtask

    task automatic t_rate();
        clear_prog();
        for (int i = 0; i < 8; i++)
            prog[i] = (i % 2 == 0) ? enc(0, 1, 2, 3) : enc(0, 4, 5, 6);
        do_reset(1'b0);
        repeat (6) @(negedge clk);
        chk(imem_addr == 8'd6, "R10", int'(imem_addr), 6);
    endtask

    task automatic t_dep_adds();   // R3
        clear_prog();
        prog[0] = enc(2, 6, 7, 0);
        prog[1] = enc(0, 1, 6, 6);
        prog[2] = enc(0, 2, 1, 6);
        prog[3] = enc(0, 3, 2, 2);
        prog[4] = enc(3, 3, 6, 0);
        prog[5] = enc(3, 2, 1, 0);
        prog[6] = enc(0, 4, 3, 1);
        prog[7] = enc(3, 4, 2, 0);
        run_and_compare("dep_adds");
    endtask

    task automatic t_load_use();   // R4
        clear_prog();
        prog[0] = enc(2, 6, 7, 0);
        prog[1] = enc(2, 1, 6, 0);
        prog[2] = enc(0, 2, 1, 1);
        prog[3] = enc(2, 3, 1, 0);
        prog[4] = enc(3, 3, 7, 0);
        prog[5] = enc(3, 2, 6, 0);
        run_and_compare("load_use");
    endtask

    task automatic t_taken_prog(); // R5
        clear_prog();
        prog[0]  = enc(2, 5, 7, 0);
        prog[1]  = enc(1, 7, 5, 0);
        prog[2]  = enc(0, 1, 5, 5);
        prog[3]  = enc(3, 5, 7, 0);
        prog[8]  = enc(0, 2, 5, 5);
        prog[9]  = enc(3, 2, 5, 0);
        prog[10] = enc(3, 1, 2, 0);
        run_and_compare("taken");
    endtask

    task automatic t_not_taken();  // R6
        clear_prog();
        prog[0] = enc(2, 5, 7, 0);
        prog[1] = enc(1, 5, 7, 0);
        prog[2] = enc(0, 1, 5, 5);
        prog[3] = enc(3, 1, 5, 0);
        prog[4] = enc(1, 1, 7, 0);
        prog[5] = enc(3, 5, 1, 0);
        run_and_compare("not_taken");
    endtask

    task automatic t_store_load(); // R4
        clear_prog();
        prog[0] = enc(2, 6, 7, 0);
        prog[1] = enc(0, 1, 6, 6);
        prog[2] = enc(3, 1, 6, 0);
        prog[3] = enc(2, 2, 6, 0);
        prog[4] = enc(0, 3, 2, 6);
        prog[5] = enc(3, 3, 7, 0);
        run_and_compare("store_load");
    endtask

    task automatic t_store_hazard(); // R8 with results
        clear_prog();
        prog[0] = enc(2, 6, 7, 0);
        prog[1] = enc(3, 6, 6, 0);
        prog[2] = enc(0, 1, 6, 6);
        prog[3] = enc(3, 1, 7, 0);
        run_and_compare("store_hazard");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_stall_vs_fwd();
        t_store_no_stall();
        t_taken_timing();
        t_rate();
        t_dep_adds();
        t_load_use();
        t_taken_prog();
        t_not_taken();
        t_store_load();
        t_store_hazard();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule